// File: doc/BRIEF.md
# Return-from-Break Sequencer

This unit executes the return-from-break instruction of a 32-bit in-order pipeline. When an issued instruction word decodes as this return, the unit first checks privilege. It then adds the sign-extended 16-bit immediate to the register-A value to form the branch target. After that it waits for the single delay-slot instruction to retire. Only then does it write the new program counter and the machine status bits. The write clears break-in-progress and loads the user-mode and virtual-mode bits from their saved copies.

While the sequence is in flight, the unit raises a defer signal whenever an interrupt or an external break is pending, so that neither is taken before the delayed branch has completed. A retiring delay-slot instruction whose opcode is an immediate prefix or any branch form is flagged as illegal. When the memory-management option is present and the machine is in user mode, the return is not executed and a privileged-instruction exception is requested instead. A parameter selects the fast or the area-optimized latency. Internal wait cycles pad the sequence so that it matches that latency.

Top module: `rtb_seq`

## Requirements
- R1: With issue_i high and the unit idle, instr_i is accepted only when instr_i[31:26] = 6'b101101 and instr_i[25:21] = 5'b10010; any other word leaves busy_o low and produces no write. ra_idx_o always equals instr_i[20:16].
- R2: On a commit, pc_o equals the captured register-A value plus instr_i[15:0] sign-extended to 32 bits, with modulo-2^32 wraparound.
- R3: Latency L is 2 when AREA_OPT = 0, 6 when AREA_OPT = 1, plus 2 more when AREA_OPT = 1 and MMU_LEVEL > 1. If issue is sampled at clock edge e and the slot has already retired, the commit pulse appears in the cycle after edge e+L-1, and never earlier.
- R4: A commit waits for slot_retire_i. If the strobe arrives at or after the earliest commit cycle, pc_we_o rises in the same cycle as the strobe.
- R5: On a commit, pc_we_o and msr_we_o are high together for one cycle, msr_bip_o is 0, and msr_um_o and msr_vm_o equal msr_ums_i and msr_vms_i as sampled at issue. msr_bip_o is 1 in every other cycle.
- R6: When MMU_LEVEL >= 1 and msr_um_i is 1 at issue, exc_req_o pulses with exc_code_o = 5'b00111 in the cycle after the issue edge. No PC or status write occurs, and busy_o falls on the next edge.
- R7: defer_o is high exactly when busy_o is high and irq_i or brk_i is high.
- R8: issue_i is ignored while busy_o is high, so the in-flight target and status bits are unchanged.
- R9: slot_illegal_o is high in a cycle where busy_o and slot_retire_i are high and slot_opc_i is one of 6'b101100, 6'b100110, 6'b101110, 6'b100111, 6'b101111, 6'b101101. It is low otherwise.
- R10: After reset, busy_o, pc_we_o, msr_we_o and exc_req_o are low.
- R11: Each accepted return produces exactly one commit pulse or one exception pulse, and busy_o falls on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| ra_val_i | input | 32 | Register-A operand value |
| msr_um_i | input | 1 | Current user-mode bit |
| msr_ums_i | input | 1 | Saved user-mode bit |
| msr_vms_i | input | 1 | Saved virtual-mode bit |
| slot_retire_i | input | 1 | Delay-slot instruction retired |
| slot_opc_i | input | 6 | Opcode of the retiring slot instruction |
| irq_i | input | 1 | Interrupt pending |
| brk_i | input | 1 | External break pending |
| ra_idx_o | output | 5 | Register-A index for the register file read |
| busy_o | output | 1 | Sequence in flight |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | 32 | New PC |
| msr_we_o | output | 1 | Status write strobe |
| msr_bip_o | output | 1 | Break-in-progress value |
| msr_um_o | output | 1 | New user-mode bit |
| msr_vm_o | output | 1 | New virtual-mode bit |
| exc_req_o | output | 1 | Exception request |
| exc_code_o | output | 5 | Exception code |
| slot_illegal_o | output | 1 | Illegal delay-slot instruction |
| defer_o | output | 1 | Hold off interrupts and breaks |

## Verification
The hardest case to reach is the overlap of the delay-slot strobe with the padded wait. A strobe that lands during the wait cycles must be remembered, while one that arrives after the earliest commit cycle must trigger the write in that same cycle. The driver places the slot strobe at offsets before, exactly at, and well after the latency boundary, and the scoreboard predicts the commit cycle as the later of the two. A second issue is injected while busy, and pending interrupts are held across the sequence.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int XLEN   = 32;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int OPC_W  = 6;
  localparam int SUB_W  = 5;
  localparam int REG_W  = 5;
  localparam int EXC_W  = 5;

  localparam logic [OPC_W-1:0] OPC_RET  = 6'b101101;
  localparam logic [SUB_W-1:0] SUB_RTB  = 5'b10010;
  localparam logic [EXC_W-1:0] EXC_PRIV = 5'b00111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SLOT_WAIT,
    ST_COMMIT
  } rtb_state_e;

  typedef struct packed {
    logic [XLEN-1:0] target;
    logic            trap;
    logic            ums;
    logic            vms;
  } rtb_ctx_t;

  // immediate prefix and every branch / return form
  function automatic logic is_ctl_flow(input logic [OPC_W-1:0] opc);
    return opc inside {6'b101100, 6'b100110, 6'b101110,
                       6'b100111, 6'b101111, 6'b101101};
  endfunction
endpackage

// File: rtl/rtb_decode.sv
module rtb_decode
  import rtb_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   ra_val_i,
  output logic              hit_o,
  output logic [REG_W-1:0]  ra_idx_o,
  output logic [XLEN-1:0]   target_o
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int SUB_LSB = OPC_LSB - SUB_W;
  localparam int REG_LSB = SUB_LSB - REG_W;

  logic [OPC_W-1:0] opc;
  logic [SUB_W-1:0] sub;
  logic [XLEN-1:0]  imm_sx;

  assign opc      = instr_i[INSN_W-1:OPC_LSB];
  assign sub      = instr_i[OPC_LSB-1:SUB_LSB];
  assign ra_idx_o = instr_i[SUB_LSB-1:REG_LSB];
  assign imm_sx   = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign hit_o    = (opc == OPC_RET) && (sub == SUB_RTB);
  assign target_o = ra_val_i + imm_sx;
endmodule

// File: rtl/rtb_slot_chk.sv
module rtb_slot_chk
  import rtb_pkg::*;
(
  input  logic             active_i,
  input  logic             retire_i,
  input  logic [OPC_W-1:0] opc_i,
  output logic             illegal_o
);
  assign illegal_o = active_i && retire_i && is_ctl_flow(opc_i);
endmodule

// File: rtl/rtb_ctrl.sv
module rtb_ctrl
  import rtb_pkg::*;
#(
  parameter int WAIT_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  rtb_ctx_t ctx_i,
  input  logic     slot_retire_i,
  output logic     busy_o,
  output logic     commit_o,
  output logic     exc_o,
  output rtb_ctx_t ctx_o
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  rtb_state_e state_q, state_d;
  rtb_ctx_t   ctx_q;
  logic       slot_seen_q;
  logic       wait_done;

  generate
    if (WAIT_CYC == 0) begin : g_nowait
      assign wait_done = 1'b1;
    end else begin : g_wait
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    cnt_q <= '0;
        else if (state_q == ST_CHECK)                   cnt_q <= CNT_W'(WAIT_CYC - 1);
        else if (state_q == ST_SLOT_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign wait_done = (cnt_q == '0);
    end
  endgenerate

  assign commit_o = (state_q == ST_COMMIT) && (slot_seen_q || slot_retire_i);
  assign exc_o    = (state_q == ST_CHECK) && ctx_q.trap;
  assign busy_o   = (state_q != ST_IDLE);
  assign ctx_o    = ctx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_CHECK;
      ST_CHECK:     state_d = ctx_q.trap ? ST_IDLE :
                              (WAIT_CYC == 0) ? ST_COMMIT : ST_SLOT_WAIT;
      ST_SLOT_WAIT: if (wait_done) state_d = ST_COMMIT;
      ST_COMMIT:    if (commit_o) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ctx_q       <= '0;
      slot_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: begin
          slot_seen_q <= 1'b0;
          if (start_i) ctx_q <= ctx_i;
        end
        ST_CHECK:     if (slot_retire_i && !ctx_q.trap) slot_seen_q <= 1'b1;
        ST_SLOT_WAIT: if (slot_retire_i) slot_seen_q <= 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/rtb_seq.sv
module rtb_seq
  import rtb_pkg::*;
#(
  parameter bit AREA_OPT  = 1'b1,
  parameter int MMU_LEVEL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic              msr_um_i,
  input  logic              msr_ums_i,
  input  logic              msr_vms_i,
  input  logic              slot_retire_i,
  input  logic [OPC_W-1:0]  slot_opc_i,
  input  logic              irq_i,
  input  logic              brk_i,
  output logic [REG_W-1:0]  ra_idx_o,
  output logic              busy_o,
  output logic              pc_we_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              msr_we_o,
  output logic              msr_bip_o,
  output logic              msr_um_o,
  output logic              msr_vm_o,
  output logic              exc_req_o,
  output logic [EXC_W-1:0]  exc_code_o,
  output logic              slot_illegal_o,
  output logic              defer_o
);
  localparam int  LAT      = AREA_OPT ? (6 + ((MMU_LEVEL > 1) ? 2 : 0)) : 2;
  localparam int  WAIT_CYC = LAT - 2;
  localparam bit  TRAP_EN  = (MMU_LEVEL >= 1);

  logic            hit;
  logic [XLEN-1:0] target;
  rtb_ctx_t        ctx_in, ctx;
  logic            commit, exc;

  rtb_decode u_dec (
    .instr_i  (instr_i),
    .ra_val_i (ra_val_i),
    .hit_o    (hit),
    .ra_idx_o (ra_idx_o),
    .target_o (target)
  );

  assign ctx_in.target = target;
  assign ctx_in.trap   = TRAP_EN && msr_um_i;
  assign ctx_in.ums    = msr_ums_i;
  assign ctx_in.vms    = msr_vms_i;

  rtb_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (issue_i && hit),
    .ctx_i         (ctx_in),
    .slot_retire_i (slot_retire_i),
    .busy_o        (busy_o),
    .commit_o      (commit),
    .exc_o         (exc),
    .ctx_o         (ctx)
  );

  rtb_slot_chk u_slot (
    .active_i  (busy_o),
    .retire_i  (slot_retire_i),
    .opc_i     (slot_opc_i),
    .illegal_o (slot_illegal_o)
  );

  assign pc_we_o    = commit;
  assign msr_we_o   = commit;
  assign pc_o       = ctx.target;
  assign msr_bip_o  = !commit;
  assign msr_um_o   = ctx.ums;
  assign msr_vm_o   = ctx.vms;
  assign exc_req_o  = exc;
  assign exc_code_o = exc ? EXC_PRIV : '0;
  assign defer_o    = busy_o && (irq_i || brk_i);
endmodule

// File: rtl/rtb_seq_chk.sv
module rtb_seq_chk #(
  parameter bit AREA_OPT  = 1'b1,
  parameter int MMU_LEVEL = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       pc_we_o,
  input logic       msr_we_o,
  input logic       msr_bip_o,
  input logic       exc_req_o,
  input logic [4:0] exc_code_o,
  input logic       defer_o,
  input logic       irq_i,
  input logic       brk_i,
  input logic       slot_illegal_o
);
  localparam int LAT = AREA_OPT ? (6 + ((MMU_LEVEL > 1) ? 2 : 0)) : 2;

  logic [7:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_cnt <= '0;
    else if (!busy_o)           busy_cnt <= '0;
    else if (busy_cnt != 8'hff) busy_cnt <= busy_cnt + 8'd1;
  end

  p_commit_bip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (msr_we_o && !msr_bip_o));
  p_exc_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_code_o == 5'b00111 && !pc_we_o && !msr_we_o));
  p_exc_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> !busy_o);
  p_commit_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> !busy_o);
  p_min_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (busy_cnt >= 8'(LAT - 1)));
  p_defer_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !defer_o);
  p_defer_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (irq_i || brk_i)) |-> defer_o);
  p_illegal_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !slot_illegal_o);
endmodule

bind rtb_seq rtb_seq_chk #(.AREA_OPT(AREA_OPT), .MMU_LEVEL(MMU_LEVEL)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .pc_we_o        (pc_we_o),
  .msr_we_o       (msr_we_o),
  .msr_bip_o      (msr_bip_o),
  .exc_req_o      (exc_req_o),
  .exc_code_o     (exc_code_o),
  .defer_o        (defer_o),
  .irq_i          (irq_i),
  .brk_i          (brk_i),
  .slot_illegal_o (slot_illegal_o)
);

// File: tb/test_rtb_seq.sv
module test_rtb_seq;
  localparam int L = 6;  // AREA_OPT=1, MMU_LEVEL=1

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] ra_val_i = '0;
  logic        msr_um_i = 1'b0, msr_ums_i = 1'b0, msr_vms_i = 1'b0;
  logic        slot_retire_i = 1'b0;
  logic [5:0]  slot_opc_i = '0;
  logic        irq_i = 1'b0, brk_i = 1'b0;
  logic [4:0]  ra_idx_o;
  logic        busy_o, pc_we_o, msr_we_o, msr_bip_o, msr_um_o, msr_vm_o;
  logic [31:0] pc_o;
  logic        exc_req_o, slot_illegal_o, defer_o;
  logic [4:0]  exc_code_o;

  always #10 clk = ~clk;

  rtb_seq i_rtb_seq (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i), .instr_i(instr_i),
    .ra_val_i(ra_val_i), .msr_um_i(msr_um_i), .msr_ums_i(msr_ums_i),
    .msr_vms_i(msr_vms_i), .slot_retire_i(slot_retire_i), .slot_opc_i(slot_opc_i),
    .irq_i(irq_i), .brk_i(brk_i), .ra_idx_o(ra_idx_o), .busy_o(busy_o),
    .pc_we_o(pc_we_o), .pc_o(pc_o), .msr_we_o(msr_we_o), .msr_bip_o(msr_bip_o),
    .msr_um_o(msr_um_o), .msr_vm_o(msr_vm_o), .exc_req_o(exc_req_o),
    .exc_code_o(exc_code_o), .slot_illegal_o(slot_illegal_o), .defer_o(defer_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit          is_exc;
    int          at;
    logic [31:0] pc;
    logic        um;
    logic        vm;
  } exp_t;
  exp_t q[$];

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] sub,
                                     input logic [4:0] ra, input logic [15:0] imm);
    return {opc, sub, ra, imm};
  endfunction

  function automatic bit ctl_opc(input logic [5:0] o);
    return o == 6'b101100 || o == 6'b100110 || o == 6'b101110 ||
           o == 6'b100111 || o == 6'b101111 || o == 6'b101101;
  endfunction

  // monitor: 5 ns after the falling edge
  initial forever begin
    @(posedge clk);
    #15;
    if (rst_ni && (pc_we_o || exc_req_o)) begin
      if (q.size() == 0) begin
        chk(0, "R11", "unexpected write", {30'd0, pc_we_o, exc_req_o}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(exc_req_o == e.is_exc, "R6", "exception vs commit", 32'(exc_req_o), 32'(e.is_exc));
        chk(cyc == e.at, e.is_exc ? "R6" : "R3", "event cycle", cyc, e.at);
        if (e.is_exc) begin
          chk(exc_code_o == 5'b00111, "R6", "exception code", 32'(exc_code_o), 32'h7);
          chk(!pc_we_o && !msr_we_o, "R6", "write on trap", 32'(pc_we_o), 32'd0);
        end else begin
          chk(pc_o == e.pc, "R2", "target", pc_o, e.pc);
          chk(msr_we_o && !msr_bip_o, "R5", "status write / bip", {msr_we_o, msr_bip_o}, 32'h2);
          chk(msr_um_o == e.um && msr_vm_o == e.vm, "R5", "mode bits",
              {msr_um_o, msr_vm_o}, {e.um, e.vm});
        end
      end
    end
  end

  task automatic run_rtb(input logic [31:0] ra, input logic [15:0] imm,
                         input logic ums, input logic vms, input int d,
                         input logic [5:0] sopc);
    int   k;
    exp_t e;
    @(negedge clk);
    k = cyc;
    issue_i = 1'b1; instr_i = mk(6'b101101, 5'b10010, 5'd16, imm);
    ra_val_i = ra; msr_um_i = 1'b0; msr_ums_i = ums; msr_vms_i = vms;
    e.is_exc = 0; e.at = (d > L) ? k + d : k + L;
    e.pc = ra + {{16{imm[15]}}, imm}; e.um = ums; e.vm = vms;
    q.push_back(e);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      issue_i = 1'b0;
      ra_val_i = 32'hdead_beef; msr_ums_i = ~ums; msr_vms_i = ~vms;
    end
    slot_retire_i = 1'b1; slot_opc_i = sopc;
    #1;
    chk(slot_illegal_o == ctl_opc(sopc), "R9", "slot illegal flag",
        32'(slot_illegal_o), 32'(ctl_opc(sopc)));
    chk(defer_o == (irq_i || brk_i), "R7", "defer while busy",
        32'(defer_o), 32'(irq_i || brk_i));
    @(negedge clk);
    slot_retire_i = 1'b0;
    while (busy_o) @(negedge clk);
    #1;
    chk(!defer_o, "R7", "defer when idle", 32'(defer_o), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !pc_we_o && !msr_we_o && !exc_req_o, "R10", "reset outputs",
        {busy_o, pc_we_o, msr_we_o, exc_req_o}, 32'd0);

    // R1: register index field
    instr_i = mk(6'b101101, 5'b10010, 5'd21, 16'h0);
    #1;
    chk(ra_idx_o == 5'd21, "R1", "register index", 32'(ra_idx_o), 32'd21);

    // R2/R3: slot before latency boundary
    run_rtb(32'h0000_1000, 16'h0010, 1'b0, 1'b0, 1, 6'b000000);
    // R2 negative immediate
    run_rtb(32'h0000_2000, 16'hfff0, 1'b1, 1'b0, 3, 6'b000000);
    // R2 wraparound
    run_rtb(32'hffff_fff0, 16'h0020, 1'b0, 1'b1, 2, 6'b000000);
    // R4: slot exactly at boundary, then late
    run_rtb(32'h0000_4000, 16'h0004, 1'b1, 1'b1, L, 6'b000000);
    run_rtb(32'h0000_5000, 16'h8000, 1'b0, 1'b1, L + 4, 6'b000000);
    // R7: pending interrupt / break during sequence
    irq_i = 1'b1;
    run_rtb(32'h0000_6000, 16'h0100, 1'b1, 1'b0, 2, 6'b000000);
    irq_i = 1'b0; brk_i = 1'b1;
    run_rtb(32'h0000_7000, 16'h0200, 1'b0, 1'b0, 4, 6'b000000);
    brk_i = 1'b0;
    // R9: illegal slot contents
    run_rtb(32'h0000_8000, 16'h0008, 1'b0, 1'b0, 2, 6'b101100);
    run_rtb(32'h0000_9000, 16'h000c, 1'b0, 1'b0, 3, 6'b101110);

    // R6: privileged trap
    begin
      exp_t e;
      @(negedge clk);
      issue_i = 1'b1; instr_i = mk(6'b101101, 5'b10010, 5'd16, 16'h0040);
      ra_val_i = 32'h0000_a000; msr_um_i = 1'b1; msr_ums_i = 1'b1; msr_vms_i = 1'b1;
      e.is_exc = 1; e.at = cyc + 1; e.pc = '0; e.um = 0; e.vm = 0;
      q.push_back(e);
      @(negedge clk);
      issue_i = 1'b0; msr_um_i = 1'b0;
      @(negedge clk);
      chk(!busy_o, "R6", "busy after trap", 32'(busy_o), 32'd0);
      repeat (L + 2) @(negedge clk);
    end

    // R1: non-matching word ignored
    @(negedge clk);
    issue_i = 1'b1; instr_i = mk(6'b101101, 5'b10000, 5'd16, 16'h0);
    @(negedge clk);
    issue_i = 1'b0;
    chk(!busy_o, "R1", "busy on other word", 32'(busy_o), 32'd0);
    repeat (L + 2) @(negedge clk);

    // R8: second issue while busy ignored
    begin
      exp_t e;
      @(negedge clk);
      issue_i = 1'b1; instr_i = mk(6'b101101, 5'b10010, 5'd16, 16'h0010);
      ra_val_i = 32'h0000_b000; msr_ums_i = 1'b1; msr_vms_i = 1'b0;
      e.is_exc = 0; e.at = cyc + L; e.pc = 32'h0000_b010; e.um = 1; e.vm = 0;
      q.push_back(e);
      @(negedge clk);
      ra_val_i = 32'h0000_c000; msr_ums_i = 1'b0; msr_vms_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
      slot_retire_i = 1'b1; slot_opc_i = 6'b000000;
      @(negedge clk);
      slot_retire_i = 1'b0;
      while (busy_o) @(negedge clk);
      @(negedge clk);
      chk(!busy_o, "R8", "no restart after second issue", 32'(busy_o), 32'd0);
      repeat (L + 2) @(negedge clk);
    end

    chk(q.size() == 0, "R11", "missing events", q.size(), 32'd0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule